// File: doc/BRIEF.md
# Block Refill Sequencer with Critical-Word-First Fetch

This controller services a buffer miss for a single block. Tag lookup and the choice of victim happen elsewhere. The processor presents the missing word address together with the buffer index and block address of the victim. If the victim holds modified data, the sequencer first copies every word of it out to the backing store. It then reads the new block one word per beat, starting at the word the processor asked for.

During the refill, each fetched word is written into the buffer. The first fetched word is also handed to the processor in the same cycle, so the processor can resume while the rest of the block streams in. A modified flag is kept for every buffer block. Processor writes that hit a block set its flag, and a completed refill clears it. When the store-through input is high, writes go straight to the backing store. In that mode the sequencer never performs a write-back and hit writes leave the flags alone.

The backing store is reached through separate read and write channels. Both use a valid/ready handshake with one word per beat. The buffer is reached through a combinational read port, used for write-back data, and a write port.

Top module: `blkfill_seq`

## Requirements
- R1: With store-through low, a hit write (`hit_wr_valid`) to buffer block `hit_wr_idx` marks that block modified, so a later miss that victimises it performs a write-back.
- R2: A modified victim is written out in full before any read beat is issued. Write-back starts the cycle after the request is accepted. It takes WORDS beats at addresses {`req_vblk`, offset}, with the offset rising from 0. Each beat carries the buffer word at that victim index and offset.
- R3: The first read beat of a refill addresses the requested word, whose offset is the low log2(WORDS) bits of `req_addr`. The block address comes from the remaining upper bits.
- R4: Each later read beat takes the previous offset plus one, wrapping modulo WORDS, until all WORDS words are read.
- R5: Every read beat writes its word into the buffer at the victim index and the fetched offset. The critical word is driven on `cpu_data` with `cpu_valid` high in the very cycle of its buffer write.
- R6: A victim that is not modified gets no write-back, and the first read beat is presented the cycle after acceptance.
- R7: With store-through high, hit writes do not mark blocks, and no victim is written back, even one marked earlier.
- R8: The modified flag of the refilled block is cleared when the refill completes, so an immediate second miss on that block is clean.
- R9: `req_ready` is high only while the sequencer is idle. A request held during a refill is not taken.
- R10: While a backing-store valid is high and ready is low, valid, address and data stay unchanged.
- R11: After reset, `req_ready` is high, no valid or write strobe is asserted, and all blocks are unmodified.
- R12: The processor gets its word before the refill ends. `req_ready` comes back exactly two cycles after the last read beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| store_thru | input | 1 | Store-through mode select |
| hit_wr_valid | input | 1 | Processor write hit this cycle |
| hit_wr_idx | input | log2(NBLK) | Buffer block hit by the write |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | ADDR_W | Word address of the missing word |
| req_vidx | input | log2(NBLK) | Buffer index of the victim |
| req_vblk | input | ADDR_W-log2(WORDS) | Block address of the victim |
| cpu_valid | output | 1 | Critical word delivered |
| cpu_data | output | DATA_W | Critical word to processor register |
| bs_wr_valid | output | 1 | Write-back beat valid |
| bs_wr_ready | input | 1 | Backing store accepts write beat |
| bs_wr_addr | output | ADDR_W | Write-back word address |
| bs_wr_data | output | DATA_W | Write-back word |
| bs_rd_valid | output | 1 | Read beat valid |
| bs_rd_ready | input | 1 | Read data present on this beat |
| bs_rd_addr | output | ADDR_W | Read word address |
| bs_rd_data | input | DATA_W | Read word |
| buf_rd_idx | output | log2(NBLK) | Buffer read block index |
| buf_rd_ofs | output | log2(WORDS) | Buffer read word offset |
| buf_rd_data | input | DATA_W | Buffer read word (combinational) |
| buf_we | output | 1 | Buffer write strobe |
| buf_wr_idx | output | log2(NBLK) | Buffer write block index |
| buf_wr_ofs | output | log2(WORDS) | Buffer write word offset |
| buf_wr_data | output | DATA_W | Buffer write word |

## Verification
The bench uses requested offsets of zero and of the last word. A design that fetched in plain block order, or did not wrap, would read the wrong addresses or leave buffer words stale. Dirty and clean victims are mixed, with store-through switched on over a marked block. A sequencer that tested only the flag would write back there, and one that marked blocks in store-through mode would write back after the mode is turned off. Backing-store ready is throttled in an irregular pattern. This exposes beats that advance without a handshake, and a critical word forwarded on a stalled cycle or one beat late. A request is held during a busy refill, and a design that took it would show extra read beats.

// File: rtl/blkfill_pkg.sv
package blkfill_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WB    = 2'd1,
        ST_FETCH = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/blkfill_wrap.sv
// Offset of the current refill beat: start offset plus beat count, modulo
// the block length (a power of two, so truncation performs the wrap).
module blkfill_wrap #(
    parameter int WORDS = 4
) (
    input  logic [$clog2(WORDS)-1:0] base,
    input  logic [$clog2(WORDS)-1:0] step,
    output logic [$clog2(WORDS)-1:0] ofs
);
    localparam int OFS_W = $clog2(WORDS);

    logic [OFS_W:0] sum;

    always_comb begin
        sum = {1'b0, base} + {1'b0, step};
        ofs = sum[OFS_W-1:0];
    end
endmodule

// File: rtl/blkfill_flags.sv
// One modified flag per buffer block. A set and a clear aimed at the same
// block in the same cycle resolve to set, so a fresh write is never lost.
module blkfill_flags #(
    parameter int NBLK = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_en,
    input  logic [$clog2(NBLK)-1:0] set_idx,
    input  logic                    clr_en,
    input  logic [$clog2(NBLK)-1:0] clr_idx,
    output logic [NBLK-1:0]         flags
);
    localparam int IDX_W = $clog2(NBLK);

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic mod_d, mod_q;

        always_comb begin
            mod_d = mod_q;
            if (clr_en && (clr_idx == IDX_W'(b))) mod_d = 1'b0;
            if (set_en && (set_idx == IDX_W'(b))) mod_d = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mod_q <= 1'b0;
            else        mod_q <= mod_d;
        end

        assign flags[b] = mod_q;
    end
endmodule

// File: rtl/blkfill_ctrl.sv
module blkfill_ctrl
    import blkfill_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int NBLK   = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            store_thru,
    input  logic                            victim_dirty,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [$clog2(NBLK)-1:0]         req_vidx,
    input  logic [ADDR_W-$clog2(WORDS)-1:0] req_vblk,
    output logic                            clr_en,
    output logic [$clog2(NBLK)-1:0]         clr_idx,
    output logic                            cpu_valid,
    output logic [DATA_W-1:0]               cpu_data,
    output logic                            bs_wr_valid,
    input  logic                            bs_wr_ready,
    output logic [ADDR_W-1:0]               bs_wr_addr,
    output logic [DATA_W-1:0]               bs_wr_data,
    output logic                            bs_rd_valid,
    input  logic                            bs_rd_ready,
    output logic [ADDR_W-1:0]               bs_rd_addr,
    input  logic [DATA_W-1:0]               bs_rd_data,
    output logic [$clog2(NBLK)-1:0]         buf_rd_idx,
    output logic [$clog2(WORDS)-1:0]        buf_rd_ofs,
    input  logic [DATA_W-1:0]               buf_rd_data,
    output logic                            buf_we,
    output logic [$clog2(NBLK)-1:0]         buf_wr_idx,
    output logic [$clog2(WORDS)-1:0]        buf_wr_ofs,
    output logic [DATA_W-1:0]               buf_wr_data
);
    localparam int OFS_W = $clog2(WORDS);
    localparam int BLK_W = ADDR_W - OFS_W;
    localparam int IDX_W = $clog2(NBLK);
    localparam logic [OFS_W-1:0] LAST = OFS_W'(WORDS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [OFS_W-1:0]  cnt;   // beat count within the current phase
        logic [OFS_W-1:0]  crit;  // offset of the requested word
        logic [BLK_W-1:0]  blk;   // block address being fetched
        logic [BLK_W-1:0]  vblk;  // block address of the victim
        logic [IDX_W-1:0]  vidx;  // buffer slot being replaced
    } ctx_t;

    ctx_t             c_d, c_q;
    logic [OFS_W-1:0] fetch_ofs;
    logic             beat_last;

    blkfill_wrap #(.WORDS(WORDS)) u_wrap (
        .base (c_q.crit),
        .step (c_q.cnt),
        .ofs  (fetch_ofs)
    );

    assign beat_last = (c_q.cnt == LAST);

    always_comb begin
        c_d         = c_q;
        req_ready   = 1'b0;
        clr_en      = 1'b0;
        clr_idx     = c_q.vidx;
        cpu_valid   = 1'b0;
        cpu_data    = bs_rd_data;
        bs_wr_valid = 1'b0;
        bs_wr_addr  = {c_q.vblk, c_q.cnt};
        bs_wr_data  = buf_rd_data;
        bs_rd_valid = 1'b0;
        bs_rd_addr  = {c_q.blk, fetch_ofs};
        buf_rd_idx  = c_q.vidx;
        buf_rd_ofs  = c_q.cnt;
        buf_we      = 1'b0;
        buf_wr_idx  = c_q.vidx;
        buf_wr_ofs  = fetch_ofs;
        buf_wr_data = bs_rd_data;

        unique case (c_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    c_d.crit = req_addr[OFS_W-1:0];
                    c_d.blk  = req_addr[ADDR_W-1:OFS_W];
                    c_d.vblk = req_vblk;
                    c_d.vidx = req_vidx;
                    c_d.cnt  = '0;
                    c_d.st   = (victim_dirty && !store_thru) ? ST_WB : ST_FETCH;
                end
            end
            ST_WB: begin
                bs_wr_valid = 1'b1;
                if (bs_wr_ready) begin
                    if (beat_last) begin
                        c_d.cnt = '0;
                        c_d.st  = ST_FETCH;
                    end else begin
                        c_d.cnt = c_q.cnt + OFS_W'(1);
                    end
                end
            end
            ST_FETCH: begin
                bs_rd_valid = 1'b1;
                if (bs_rd_ready) begin
                    buf_we    = 1'b1;
                    cpu_valid = (c_q.cnt == '0);
                    if (beat_last) begin
                        c_d.cnt = '0;
                        c_d.st  = ST_DONE;
                    end else begin
                        c_d.cnt = c_q.cnt + OFS_W'(1);
                    end
                end
            end
            ST_DONE: begin
                clr_en = 1'b1;
                c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/blkfill_seq.sv
module blkfill_seq #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int NBLK   = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            store_thru,
    input  logic                            hit_wr_valid,
    input  logic [$clog2(NBLK)-1:0]         hit_wr_idx,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic [ADDR_W-1:0]               req_addr,
    input  logic [$clog2(NBLK)-1:0]         req_vidx,
    input  logic [ADDR_W-$clog2(WORDS)-1:0] req_vblk,
    output logic                            cpu_valid,
    output logic [DATA_W-1:0]               cpu_data,
    output logic                            bs_wr_valid,
    input  logic                            bs_wr_ready,
    output logic [ADDR_W-1:0]               bs_wr_addr,
    output logic [DATA_W-1:0]               bs_wr_data,
    output logic                            bs_rd_valid,
    input  logic                            bs_rd_ready,
    output logic [ADDR_W-1:0]               bs_rd_addr,
    input  logic [DATA_W-1:0]               bs_rd_data,
    output logic [$clog2(NBLK)-1:0]         buf_rd_idx,
    output logic [$clog2(WORDS)-1:0]        buf_rd_ofs,
    input  logic [DATA_W-1:0]               buf_rd_data,
    output logic                            buf_we,
    output logic [$clog2(NBLK)-1:0]         buf_wr_idx,
    output logic [$clog2(WORDS)-1:0]        buf_wr_ofs,
    output logic [DATA_W-1:0]               buf_wr_data
);
    localparam int IDX_W = $clog2(NBLK);

    logic [NBLK-1:0]  mod_flags;
    logic             clr_en;
    logic [IDX_W-1:0] clr_idx;
    logic             victim_dirty;
    logic             set_en;

    assign set_en       = hit_wr_valid && !store_thru;
    assign victim_dirty = mod_flags[req_vidx];

    blkfill_flags #(.NBLK(NBLK)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .set_idx (hit_wr_idx),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .flags   (mod_flags)
    );

    blkfill_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WORDS  (WORDS),
        .NBLK   (NBLK)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .store_thru   (store_thru),
        .victim_dirty (victim_dirty),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_vidx     (req_vidx),
        .req_vblk     (req_vblk),
        .clr_en       (clr_en),
        .clr_idx      (clr_idx),
        .cpu_valid    (cpu_valid),
        .cpu_data     (cpu_data),
        .bs_wr_valid  (bs_wr_valid),
        .bs_wr_ready  (bs_wr_ready),
        .bs_wr_addr   (bs_wr_addr),
        .bs_wr_data   (bs_wr_data),
        .bs_rd_valid  (bs_rd_valid),
        .bs_rd_ready  (bs_rd_ready),
        .bs_rd_addr   (bs_rd_addr),
        .bs_rd_data   (bs_rd_data),
        .buf_rd_idx   (buf_rd_idx),
        .buf_rd_ofs   (buf_rd_ofs),
        .buf_rd_data  (buf_rd_data),
        .buf_we       (buf_we),
        .buf_wr_idx   (buf_wr_idx),
        .buf_wr_ofs   (buf_wr_ofs),
        .buf_wr_data  (buf_wr_data)
    );
endmodule

// File: rtl/blkfill_chk.sv
module blkfill_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     store_thru,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [$clog2(WORDS)-1:0] req_ofs,
    input logic                     cpu_valid,
    input logic [DATA_W-1:0]        cpu_data,
    input logic                     bs_wr_valid,
    input logic                     bs_wr_ready,
    input logic [ADDR_W-1:0]        bs_wr_addr,
    input logic [DATA_W-1:0]        bs_wr_data,
    input logic                     bs_rd_valid,
    input logic                     bs_rd_ready,
    input logic [ADDR_W-1:0]        bs_rd_addr,
    input logic                     buf_we,
    input logic [$clog2(WORDS)-1:0] buf_wr_ofs,
    input logic [DATA_W-1:0]        buf_wr_data
);
    localparam int OFS_W = $clog2(WORDS);

    logic [OFS_W-1:0] crit_q;
    logic [OFS_W-1:0] rd_ofs;
    logic [OFS_W-1:0] rd_ofs_inc;

    assign rd_ofs     = bs_rd_addr[OFS_W-1:0];
    assign rd_ofs_inc = rd_ofs + OFS_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      crit_q <= '0;
        else if (req_valid && req_ready) crit_q <= req_ofs;
    end

    AST_WB_BEFORE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        bs_wr_valid |-> !bs_rd_valid); // R2

    AST_FIRST_BEAT_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bs_rd_valid) |-> (rd_ofs == crit_q)); // R3

    AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_rd_valid && bs_rd_ready) |=> (!bs_rd_valid || rd_ofs == $past(rd_ofs_inc))); // R4

    AST_FWD_WITH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> (buf_we && buf_wr_data == cpu_data && buf_wr_ofs == crit_q)); // R5

    AST_ST_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (store_thru && req_valid && req_ready) |=> !bs_wr_valid); // R7

    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_wr_valid && !bs_wr_ready) |=>
        (bs_wr_valid && $stable(bs_wr_addr) && $stable(bs_wr_data))); // R10

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_rd_valid && !bs_rd_ready) |=> (bs_rd_valid && $stable(bs_rd_addr))); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bs_wr_valid && !bs_rd_valid && !buf_we)); // R9
endmodule

bind blkfill_seq blkfill_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WORDS  (WORDS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .store_thru  (store_thru),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_ofs     (req_addr[$clog2(WORDS)-1:0]),
    .cpu_valid   (cpu_valid),
    .cpu_data    (cpu_data),
    .bs_wr_valid (bs_wr_valid),
    .bs_wr_ready (bs_wr_ready),
    .bs_wr_addr  (bs_wr_addr),
    .bs_wr_data  (bs_wr_data),
    .bs_rd_valid (bs_rd_valid),
    .bs_rd_ready (bs_rd_ready),
    .bs_rd_addr  (bs_rd_addr),
    .buf_we      (buf_we),
    .buf_wr_ofs  (buf_wr_ofs),
    .buf_wr_data (buf_wr_data)
);

// File: tb/blkfill_seq_tb.sv
`timescale 1ns/1ps
module blkfill_seq_tb;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int WORDS  = 4;
    localparam int NBLK   = 8;
    localparam int OFS_W  = 2;
    localparam int IDX_W  = 3;
    localparam int BLK_W  = ADDR_W - OFS_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              store_thru = 1'b0;
    logic              hit_wr_valid = 1'b0;
    logic [IDX_W-1:0]  hit_wr_idx = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [IDX_W-1:0]  req_vidx = '0;
    logic [BLK_W-1:0]  req_vblk = '0;
    logic              cpu_valid;
    logic [DATA_W-1:0] cpu_data;
    logic              bs_wr_valid;
    logic              bs_wr_ready = 1'b1;
    logic [ADDR_W-1:0] bs_wr_addr;
    logic [DATA_W-1:0] bs_wr_data;
    logic              bs_rd_valid;
    logic              bs_rd_ready = 1'b1;
    logic [ADDR_W-1:0] bs_rd_addr;
    logic [DATA_W-1:0] bs_rd_data;
    logic [IDX_W-1:0]  buf_rd_idx;
    logic [OFS_W-1:0]  buf_rd_ofs;
    logic [DATA_W-1:0] buf_rd_data;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_wr_idx;
    logic [OFS_W-1:0]  buf_wr_ofs;
    logic [DATA_W-1:0] buf_wr_data;

    always #4 clk = ~clk;

    function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
        return ({20'h0, a} * 32'h9E37_79B1) ^ 32'h5A00_0000;
    endfunction

    logic [DATA_W-1:0] bmod [NBLK*WORDS];
    assign bs_rd_data  = pat(bs_rd_addr);
    assign buf_rd_data = bmod[{buf_rd_idx, buf_rd_ofs}];

    blkfill_seq u_dut (.*);

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit stall_en = 1'b0;
    int ph = 0;

    // monitor state
    logic [ADDR_W-1:0] wr_a [16];
    logic [DATA_W-1:0] wr_d [16];
    logic [ADDR_W-1:0] rd_a [16];
    int wr_n, rd_n, seq, last_wr_seq, first_rd_seq, last_rd_cyc;
    int first_wrv_cyc, first_rdv_cyc;
    int cpu_n, cpu_rdn, cpu_cyc;
    logic [DATA_W-1:0] cpu_d;
    bit cpu_same;
    int hs_bad = 0;
    bit pw_stall = 0, pr_stall = 0;
    logic [ADDR_W-1:0] pw_a, pr_a;
    logic [DATA_W-1:0] pw_d;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(posedge clk);
            #1;
            ph++;
            bs_wr_ready = !stall_en || (ph % 3 != 1);
            bs_rd_ready = !stall_en || (ph % 4 != 2);
        end
    end

    always @(negedge clk) begin
        if (pw_stall && !(bs_wr_valid && bs_wr_addr == pw_a && bs_wr_data == pw_d)) hs_bad++;
        if (pr_stall && !(bs_rd_valid && bs_rd_addr == pr_a)) hs_bad++;
        pw_stall = bs_wr_valid && !bs_wr_ready; pw_a = bs_wr_addr; pw_d = bs_wr_data;
        pr_stall = bs_rd_valid && !bs_rd_ready; pr_a = bs_rd_addr;
        if (bs_wr_valid && first_wrv_cyc < 0) first_wrv_cyc = cyc;
        if (bs_rd_valid && first_rdv_cyc < 0) first_rdv_cyc = cyc;
        if (cpu_valid) begin
            cpu_n++; cpu_d = cpu_data; cpu_rdn = rd_n; cpu_cyc = cyc;
            cpu_same = buf_we && (buf_wr_data == cpu_data);
        end
        if (bs_wr_valid && bs_wr_ready) begin
            if (wr_n < 16) begin wr_a[wr_n] = bs_wr_addr; wr_d[wr_n] = bs_wr_data; end
            wr_n++; last_wr_seq = seq; seq++;
        end
        if (bs_rd_valid && bs_rd_ready) begin
            if (rd_n < 16) rd_a[rd_n] = bs_rd_addr;
            if (rd_n == 0) first_rd_seq = seq;
            rd_n++; seq++; last_rd_cyc = cyc;
        end
        if (buf_we) bmod[{buf_wr_idx, buf_wr_ofs}] = buf_wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hit_write(input int idx);
        @(negedge clk);
        hit_wr_valid = 1'b1; hit_wr_idx = IDX_W'(idx);
        @(negedge clk);
        hit_wr_valid = 1'b0;
    endtask

    // One miss; checks its own results.
    task automatic miss(input logic [ADDR_W-1:0] addr, input int vidx,
                        input logic [BLK_W-1:0] vblk, input bit exp_wb,
                        input bit hold, input bit stall, input string wb_req);
        logic [DATA_W-1:0] old [WORDS];
        int acc_cyc, ret_cyc, bad, guard;
        logic [OFS_W-1:0] crit;
        logic [BLK_W-1:0] blk;
        crit = addr[OFS_W-1:0];
        blk  = addr[ADDR_W-1:OFS_W];
        @(negedge clk);
        for (int i = 0; i < WORDS; i++) old[i] = bmod[vidx*WORDS + i];
        wr_n = 0; rd_n = 0; seq = 0; last_wr_seq = -1; first_rd_seq = -1;
        first_wrv_cyc = -1; first_rdv_cyc = -1; cpu_n = 0; cpu_rdn = -1;
        stall_en = stall;
        chk(req_ready == 1'b1, "R9", "ready before request", 64'(req_ready), 64'h1);
        req_valid = 1'b1; req_addr = addr; req_vidx = IDX_W'(vidx); req_vblk = vblk;
        acc_cyc = cyc;
        @(negedge clk);
        if (hold) req_addr = addr ^ 12'h800;
        else      req_valid = 1'b0;
        ret_cyc = -1; guard = 0;
        while (ret_cyc < 0 && guard < 400) begin
            if (req_ready) begin
                ret_cyc = cyc;
                req_valid = 1'b0;
            end else begin
                @(negedge clk);
                guard++;
            end
        end
        stall_en = 1'b0;
        chk(ret_cyc >= 0, "R9", "sequencer returned to idle", 64'(guard), 64'h0);
        chk(wr_n == (exp_wb ? WORDS : 0), wb_req, "write-back beat count",
            64'(wr_n), 64'(exp_wb ? WORDS : 0));
        if (exp_wb) begin
            bad = 0;
            for (int i = 0; i < WORDS; i++)
                if (wr_a[i] != {vblk, OFS_W'(i)} || wr_d[i] != old[i]) bad++;
            chk(bad == 0, "R2", "write-back addresses/data", 64'(bad), 64'h0);
            chk(last_wr_seq < first_rd_seq, "R2", "write-back before refill",
                64'(last_wr_seq), 64'(first_rd_seq));
            chk(first_wrv_cyc == acc_cyc + 1, "R2", "write-back start cycle",
                64'(first_wrv_cyc), 64'(acc_cyc + 1));
        end else begin
            chk(first_rdv_cyc == acc_cyc + 1, "R6", "clean victim fetch start",
                64'(first_rdv_cyc), 64'(acc_cyc + 1));
        end
        chk(rd_n == WORDS, "R4", "read beat count", 64'(rd_n), 64'(WORDS));
        chk(rd_a[0] == addr, "R3", "first read address", 64'(rd_a[0]), 64'(addr));
        bad = 0;
        for (int i = 1; i < WORDS; i++)
            if (rd_a[i] != {blk, OFS_W'(crit + OFS_W'(i))}) bad++;
        chk(bad == 0, "R4", "wrapped read order", 64'(bad), 64'h0);
        chk(cpu_n == 1 && cpu_d == pat(addr), "R5", "critical word to processor",
            64'(cpu_d), 64'(pat(addr)));
        chk(cpu_same && cpu_rdn == 0, "R5", "forward in same cycle as first fill",
            64'(cpu_rdn), 64'h0);
        bad = 0;
        for (int j = 0; j < WORDS; j++)
            if (bmod[vidx*WORDS + j] != pat({blk, OFS_W'(j)})) bad++;
        chk(bad == 0, "R5", "buffer block refilled", 64'(bad), 64'h0);
        chk(cpu_cyc < last_rd_cyc && ret_cyc == last_rd_cyc + 2, "R12",
            "release and idle timing", 64'(ret_cyc), 64'(last_rd_cyc + 2));
        if (hold) begin
            repeat (3) @(negedge clk);
            chk(rd_n == WORDS && wr_n == (exp_wb ? WORDS : 0) && req_ready, "R9",
                "held request not taken while busy", 64'(rd_n), 64'(WORDS));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready && !bs_wr_valid && !bs_rd_valid && !buf_we && !cpu_valid, "R11",
            "reset outputs", {59'h0, req_ready, bs_wr_valid, bs_rd_valid, buf_we, cpu_valid},
            64'h10);
    endtask

    task automatic t_clean_after_reset();
        miss(12'h040, 0, 10'h3A0, 1'b0, 1'b0, 1'b0, "R11");
    endtask

    task automatic t_clean_wrap_stall();
        miss(12'h12E, 2, 10'h001, 1'b0, 1'b0, 1'b1, "R6");
    endtask

    task automatic t_dirty_victim();
        hit_write(5);
        miss(12'h2B7, 5, 10'h155, 1'b1, 1'b0, 1'b1, "R1");
    endtask

    task automatic t_flag_cleared();
        miss(12'h301, 5, 10'h0C0, 1'b0, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_store_through();
        hit_write(7);
        @(negedge clk); store_thru = 1'b1;
        hit_write(6);
        miss(12'h0C6, 7, 10'h031, 1'b0, 1'b0, 1'b0, "R7");
        @(negedge clk); store_thru = 1'b0;
        miss(12'h3FF, 6, 10'h2AA, 1'b0, 1'b0, 1'b1, "R7");
    endtask

    task automatic t_busy_hold();
        hit_write(3);
        miss(12'h555, 3, 10'h111, 1'b1, 1'b1, 1'b1, "R1");
    endtask

    initial begin
        for (int i = 0; i < NBLK*WORDS; i++) bmod[i] = 32'hB000_0000 + 32'(i);
        wr_n = 0; rd_n = 0; seq = 0; first_wrv_cyc = -1; first_rdv_cyc = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clean_after_reset();
        t_clean_wrap_stall();
        t_dirty_victim();
        t_flag_cleared();
        t_store_through();
        t_busy_hold();
        chk(hs_bad == 0, "R10", "handshake hold under stall", 64'(hs_bad), 64'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R9 run hung actual=%0d expected=<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule